// File: doc/BRIEF.md
# Chained Step-Attenuator Serial Programmer

This block sits on the host side of a serial control bus and programs a chain of step-attenuator control slaves. All slaves share one clock line and one active-low select line, and each slave's serial output feeds the next slave's serial input. A single start request carries one 6-bit attenuation code per device. The block can first pulse an active-low reset line to the whole chain. It then lowers select, shifts one 8-bit word per device, and raises select once so that every device takes its new code on the same edge.

The word meant for the device at the far end of the chain leaves first. After all words have been shifted, each device therefore holds its own word. The serial clock period, the reset pulse, the reset-to-clock gap and the select hold-off are all derived from the system clock period through parameters. An optional readback check listens to the serial output of the device nearest the host. That device returns the first word it received after an 8-clock delay, and the block flags any bit that differs from the word it sent.

Top module: `atten_chain_master`

## Requirements
- R1: While rst_n is low, and after it is released, cs_n_o is 1, sck_o is 0, dev_rst_n_o is 1, busy_o is 0 and mismatch_o is 0.
- R2: Each device word is 8 bits sent least significant bit first. Word bits 0 and 1 are reserved and sent as 0, and word bits 2..7 carry code bits 0..5.
- R3: codes_i[k*6 +: 6] is the code for device k, where device 0 is the one whose input is driven by sdi_o. The word for device N_DEV-1 is sent first and the word for device 0 last. A frame has exactly N_DEV*8 rising sck_o edges.
- R4: While cs_n_o stays low, sdi_o changes only in the cycle in which sck_o falls. A slave samples sdi_o on the rising edge of sck_o.
- R5: The sck_o period is 2*HALF_CYC system cycles, where HALF_CYC is the smallest count that keeps the clock at or below 20 MHz. With the defaults this is 4 cycles (80 ns).
- R6: cs_n_o falls once and rises once per frame. The rise comes exactly CS_SETUP_CYC cycles (at least 40 ns; 2 cycles by default) after the last falling sck_o edge.
- R7: When do_reset_i is high with an accepted start, dev_rst_n_o goes low for RST_PULSE_CYC cycles (2 by default) while cs_n_o is high. The first rising sck_o edge comes at least 20 ns (RST_GAP_CYC cycles) after dev_rst_n_o returns high.
- R8: Whenever busy_o is 0, cs_n_o is 1, sck_o is 0 and dev_rst_n_o is 1.
- R9: busy_o rises in the cycle after an accepted start and falls in the same cycle that cs_n_o rises. A start request while busy_o is 1 is ignored and does not alter the frame in progress or cause a further frame.
- R10: When check_en_i is high at start, sdo_i is sampled at rising sck_o edges 9 to 16 and compared with the first word sent, bit 0 first. mismatch_o is then 1 after the frame if any bit differed. mismatch_o clears on the next accepted start and stays 0 when check_en_i was low. Readback needs N_DEV of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| start_i | input | 1 | Request to program the chain; accepted only when idle |
| do_reset_i | input | 1 | Pulse the chain reset line before shifting |
| check_en_i | input | 1 | Enable readback comparison for this frame |
| codes_i | input | N_DEV*6 | One 6-bit attenuation code per device, device k at bits k*6 +: 6 |
| sdo_i | input | 1 | Serial return from the device nearest the host |
| busy_o | output | 1 | High from start until select returns high |
| sck_o | output | 1 | Serial clock to the chain |
| sdi_o | output | 1 | Serial data to the chain |
| cs_n_o | output | 1 | Active-low shared select; rising edge latches all devices |
| dev_rst_n_o | output | 1 | Active-low reset to the chain |
| mismatch_o | output | 1 | Readback differed from the first word sent |

## Verification
The properties assume that start_i, do_reset_i and check_en_i are synchronous to clk. They also assume that sdo_i carries the chain's return, so it may hold unknown data until the first word has passed through. The compare logic therefore only looks at sdo_i inside its sampling window. The stimulus changes every input on the falling clk edge. It pulses start_i for a single cycle, except for one deliberate extra request while a frame is running. It drives sdo_i from a behavioural model of two chained slaves, with an optional inversion that produces a readback error on purpose.

// File: rtl/atten_chain_pkg.sv
package atten_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_GAP,
        ST_SCK_LOW,
        ST_SCK_HIGH,
        ST_TAIL
    } seq_state_e;

    // Smallest whole number of system cycles covering a time in ns (at least one).
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/atten_frame_pack.sv
module atten_frame_pack #(
    parameter int N_DEV  = 2,
    parameter int CODE_W = 6,
    parameter int RSV_W  = 2
) (
    input  logic [N_DEV*CODE_W-1:0]          codes_i,
    output logic [N_DEV*(CODE_W+RSV_W)-1:0]  frame_o,
    output logic [CODE_W+RSV_W-1:0]          lead_word_o
);
    localparam int WORD_W = CODE_W + RSV_W;

    // Bit i of frame_o is the i-th bit on the wire; the far device's word goes first (R3),
    // each word carries reserved zeros in its low bits and the code above them (R2).
    for (genvar g = 0; g < N_DEV; g++) begin : g_word
        assign frame_o[(N_DEV-1-g)*WORD_W +: WORD_W] =
            {codes_i[g*CODE_W +: CODE_W], {RSV_W{1'b0}}};
    end

    assign lead_word_o = frame_o[WORD_W-1:0];

endmodule

// File: rtl/atten_readback_cmp.sv
module atten_readback_cmp #(
    parameter int WORD_W = 8,
    parameter int BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              enable_i,
    input  logic [WORD_W-1:0] expect_i,
    input  logic              sample_i,
    input  logic [BIT_W-1:0]  bit_idx_i,
    input  logic              sdo_i,
    output logic              mismatch_o
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] ref_w;
        logic              mis;
    } cmp_t;

    cmp_t cmp_d, cmp_q;
    logic             in_win;
    logic [IDX_W-1:0] rel_idx;

    always_comb begin
        cmp_d   = cmp_q;
        in_win  = (int'(bit_idx_i) >= WORD_W) && (int'(bit_idx_i) < 2*WORD_W);
        rel_idx = IDX_W'(int'(bit_idx_i) - WORD_W);
        if (arm_i) begin
            cmp_d.en    = enable_i;
            cmp_d.ref_w = expect_i;
            cmp_d.mis   = 1'b0;
        end else if (cmp_q.en && sample_i && in_win) begin
            if (sdo_i != cmp_q.ref_w[rel_idx]) begin
                cmp_d.mis = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign mismatch_o = cmp_q.mis;

    // R10: the flag can only be raised while the compare is enabled for the frame
    a_r10_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_q.mis) |-> $past(cmp_q.en));

    // R10: an arm always leaves the flag clear
    a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !mismatch_o);

endmodule

// File: rtl/atten_chain_master.sv
module atten_chain_master
    import atten_chain_pkg::*;
#(
    parameter int N_DEV             = 2,
    parameter int CODE_W            = 6,
    parameter int RSV_W             = 2,
    parameter int SYS_PERIOD_NS     = 20,
    parameter int SCK_MIN_PERIOD_NS = 50,
    parameter int RST_SETUP_NS      = 20,
    parameter int CS_SETUP_NS       = 40,
    parameter int RST_PULSE_CYC     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    do_reset_i,
    input  logic                    check_en_i,
    input  logic [N_DEV*CODE_W-1:0] codes_i,
    input  logic                    sdo_i,
    output logic                    busy_o,
    output logic                    sck_o,
    output logic                    sdi_o,
    output logic                    cs_n_o,
    output logic                    dev_rst_n_o,
    output logic                    mismatch_o
);
    localparam int WORD_W       = CODE_W + RSV_W;
    localparam int FRAME_W      = N_DEV * WORD_W;
    localparam int BIT_W        = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int HALF_CYC     = ns_to_cyc((SCK_MIN_PERIOD_NS + 1) / 2, SYS_PERIOD_NS);
    localparam int RST_GAP_CYC  = ns_to_cyc(RST_SETUP_NS, SYS_PERIOD_NS);
    localparam int CS_SETUP_CYC = ns_to_cyc(CS_SETUP_NS, SYS_PERIOD_NS);
    localparam int MAX_CYC      = max4(HALF_CYC, RST_GAP_CYC, CS_SETUP_CYC, RST_PULSE_CYC);
    localparam int TMR_W        = $clog2(MAX_CYC + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [TMR_W-1:0]   tmr;
        logic [BIT_W-1:0]   bit_idx;
        logic [FRAME_W-1:0] shreg;
        logic               sck;
        logic               sdi;
        logic               cs_n;
        logic               dev_rst_n;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [FRAME_W-1:0] frame;
    logic [WORD_W-1:0]  lead_word;
    logic               accept;
    logic               sample;

    atten_frame_pack #(
        .N_DEV (N_DEV),
        .CODE_W(CODE_W),
        .RSV_W (RSV_W)
    ) pack_i (
        .codes_i    (codes_i),
        .frame_o    (frame),
        .lead_word_o(lead_word)
    );

    always_comb begin
        seq_d  = seq_q;
        accept = 1'b0;
        sample = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.cs_n      = 1'b1;
                seq_d.sck       = 1'b0;
                seq_d.dev_rst_n = 1'b1;
                if (start_i) begin
                    accept        = 1'b1;
                    seq_d.shreg   = frame;
                    seq_d.bit_idx = '0;
                    if (do_reset_i) begin
                        seq_d.st        = ST_RST_LOW;
                        seq_d.dev_rst_n = 1'b0;
                        seq_d.tmr       = TMR_W'(RST_PULSE_CYC - 1);
                    end else begin
                        seq_d.st   = ST_SCK_LOW;
                        seq_d.cs_n = 1'b0;
                        seq_d.sdi  = frame[0];
                        seq_d.tmr  = TMR_W'(HALF_CYC - 1);
                    end
                end
            end
            ST_RST_LOW: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st        = ST_RST_GAP;
                    seq_d.dev_rst_n = 1'b1;
                    seq_d.tmr       = TMR_W'(RST_GAP_CYC - 1);
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_RST_GAP: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st   = ST_SCK_LOW;
                    seq_d.cs_n = 1'b0;
                    seq_d.sdi  = seq_q.shreg[0];
                    seq_d.tmr  = TMR_W'(HALF_CYC - 1);
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_SCK_LOW: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st  = ST_SCK_HIGH;
                    seq_d.sck = 1'b1;
                    sample    = 1'b1;
                    seq_d.tmr = TMR_W'(HALF_CYC - 1);
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_SCK_HIGH: begin
                if (seq_q.tmr == '0) begin
                    seq_d.sck = 1'b0;
                    if (seq_q.bit_idx == LAST_BIT) begin
                        seq_d.st  = ST_TAIL;
                        seq_d.tmr = TMR_W'(CS_SETUP_CYC - 1);
                    end else begin
                        seq_d.st      = ST_SCK_LOW;
                        seq_d.bit_idx = seq_q.bit_idx + 1'b1;
                        seq_d.shreg   = seq_q.shreg >> 1;
                        seq_d.sdi     = seq_q.shreg[1];
                        seq_d.tmr     = TMR_W'(HALF_CYC - 1);
                    end
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_TAIL: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.cs_n = 1'b1;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q           <= '0;
            seq_q.st        <= ST_IDLE;
            seq_q.cs_n      <= 1'b1;
            seq_q.dev_rst_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    atten_readback_cmp #(
        .WORD_W(WORD_W),
        .BIT_W (BIT_W)
    ) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (accept),
        .enable_i  (check_en_i),
        .expect_i  (lead_word),
        .sample_i  (sample),
        .bit_idx_i (seq_q.bit_idx),
        .sdo_i     (sdo_i),
        .mismatch_o(mismatch_o)
    );

    assign busy_o      = (seq_q.st != ST_IDLE);
    assign sck_o       = seq_q.sck;
    assign sdi_o       = seq_q.sdi;
    assign cs_n_o      = seq_q.cs_n;
    assign dev_rst_n_o = seq_q.dev_rst_n;

    // Checker-only run-length counters for the timing windows
    logic [TMR_W-1:0] low_run_q;
    logic [TMR_W-1:0] rst_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            rst_run_q <= '0;
        end else begin
            if (sck_o) low_run_q <= '0;
            else if (low_run_q < TMR_W'(CS_SETUP_CYC)) low_run_q <= low_run_q + 1'b1;
            if (!dev_rst_n_o) rst_run_q <= '0;
            else if (rst_run_q < TMR_W'(RST_GAP_CYC)) rst_run_q <= rst_run_q + 1'b1;
        end
    end

    // R8: the bus is quiet whenever no frame is in progress
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sck_o && dev_rst_n_o));

    // R4: data moves only with a falling clock while selected
    a_r4_sdi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $past(!cs_n_o) && !$stable(sdi_o)) |-> $fell(sck_o));

    // R6: select rises only after the hold-off following the last clock edge
    a_r6_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (low_run_q >= TMR_W'(CS_SETUP_CYC)));

    // R7: first clock edge respects the reset-to-clock gap
    a_r7_rst_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> (rst_run_q >= TMR_W'(RST_GAP_CYC)));

    // R7: the chain reset is only pulsed while deselected
    a_r7_rst_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n_o |-> cs_n_o);

    // R9: busy ends exactly with the select rise
    a_r9_busy_ends_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $rose(cs_n_o));

    // R5: a clock high phase never collapses to a single cycle when two or more are required
    if (HALF_CYC > 1) begin : g_half_chk
        a_r5_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sck_o) |=> sck_o);
    end

endmodule

// File: tb/atten_chain_master_tb.sv
module atten_chain_master_tb_top;
    localparam int N      = 2;
    localparam int CW     = 6;
    localparam int BITS   = N * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          do_reset_i = 1'b0;
    logic          check_en_i = 1'b0;
    logic [N*CW-1:0] codes_i = '0;
    logic          sdo_i;
    logic          busy_o, sck_o, sdi_o, cs_n_o, dev_rst_n_o, mismatch_o;

    atten_chain_master #(.N_DEV(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .do_reset_i(do_reset_i),
        .check_en_i(check_en_i), .codes_i(codes_i), .sdo_i(sdo_i),
        .busy_o(busy_o), .sck_o(sck_o), .sdi_o(sdi_o), .cs_n_o(cs_n_o),
        .dev_rst_n_o(dev_rst_n_o), .mismatch_o(mismatch_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural chain of slaves: device 0 is fed by sdi_o, its output returns on sdo_i
    bit [7:0]    sr  [N];
    bit [CW-1:0] act [N];
    bit          fault = 1'b0;

    always @(posedge sck_o or negedge dev_rst_n_o) begin
        if (!dev_rst_n_o) begin
            for (int k = 0; k < N; k++) sr[k] <= '0;
        end else if (!cs_n_o) begin
            sr[0] <= {sr[0][6:0], sdi_o};
            for (int k = 1; k < N; k++) sr[k] <= {sr[k][6:0], sr[k-1][7]};
        end
    end

    always @(posedge cs_n_o or negedge dev_rst_n_o) begin
        if (!dev_rst_n_o) begin
            for (int k = 0; k < N; k++) act[k] <= '0;
        end else begin
            for (int k = 0; k < N; k++)
                for (int j = 0; j < CW; j++) act[k][j] <= sr[k][5-j];
        end
    end

    assign sdo_i = sr[0][7] ^ fault;

    // Scoreboard
    typedef struct {
        logic [N*CW-1:0] codes;
        bit              rst;
        bit              mis;
    } item_t;
    item_t exp_q[$];

    int rises, last_rise, first_rise, last_fall, rst_fall, rst_rise, frames;
    bit period_bad;
    bit [CW-1:0] act_at_sel [N];
    int idle_bad = 0, sdi_bad = 0;
    logic p_sck = 1'b0, p_cs = 1'b1, p_rst = 1'b1, p_sdi = 1'b0;
    bit mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!busy_o && (cs_n_o !== 1'b1 || sck_o !== 1'b0 || dev_rst_n_o !== 1'b1)) idle_bad++;
            if (!cs_n_o && !p_cs && sdi_o !== p_sdi && !(p_sck && !sck_o)) sdi_bad++;
            if (!dev_rst_n_o && p_rst) rst_fall = cyc;
            if (dev_rst_n_o && !p_rst) rst_rise = cyc;
            if (!cs_n_o && p_cs) begin
                rises = 0; period_bad = 1'b0; last_rise = -1; first_rise = -1;
                for (int k = 0; k < N; k++) act_at_sel[k] = act[k];
            end
            if (sck_o && !p_sck) begin
                if (last_rise >= 0 && cyc - last_rise != 4) period_bad = 1'b1;
                if (first_rise < 0) first_rise = cyc;
                last_rise = cyc;
                rises++;
            end
            if (!sck_o && p_sck) last_fall = cyc;
            if (cs_n_o && !p_cs) begin
                item_t it;
                frames++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame", frames, 0);
                end else begin
                    it = exp_q.pop_front();
                    for (int k = 0; k < N; k++) begin
                        chk(act[k] == it.codes[k*CW +: CW], "R3", $sformatf("device %0d code", k),
                            act[k], it.codes[k*CW +: CW]);
                        chk(sr[k][7:6] == 2'b00, "R2", $sformatf("device %0d reserved bits", k),
                            sr[k][7:6], 0);
                    end
                    chk(rises == BITS, "R3", "rising edges per frame", rises, BITS);
                    chk(!period_bad, "R5", "sck period of 4 cycles", period_bad, 0);
                    chk(cyc - last_fall == 2, "R6", "select hold-off cycles", cyc - last_fall, 2);
                    chk(!busy_o, "R9", "busy low with select rise", busy_o, 0);
                    chk(mismatch_o == it.mis, "R10", "readback flag", mismatch_o, it.mis);
                    if (it.rst) begin
                        chk(rst_rise - rst_fall == 2, "R7", "reset pulse width", rst_rise - rst_fall, 2);
                        chk(first_rise - rst_rise >= 1, "R7", "reset to first clock", first_rise - rst_rise, 1);
                        chk(act_at_sel[0] == 0 && act_at_sel[1] == 0, "R7", "max attenuation after reset",
                            {act_at_sel[1], act_at_sel[0]}, 0);
                    end
                end
            end
        end
        p_sck = sck_o; p_cs = cs_n_o; p_rst = dev_rst_n_o; p_sdi = sdi_o;
    end

    task automatic run_txn(input logic [CW-1:0] c1, input logic [CW-1:0] c0,
                           input bit rst, input bit chk_en, input bit flt, input bit poke);
        item_t it;
        @(negedge clk);
        fault = flt;
        codes_i = {c1, c0};
        do_reset_i = rst;
        check_en_i = chk_en;
        start_i = 1'b1;
        it.codes = {c1, c0}; it.rst = rst; it.mis = chk_en && flt;
        exp_q.push_back(it);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        chk(mismatch_o == 1'b0, "R10", "flag cleared by start", mismatch_o, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            codes_i = {6'h11, 6'h22};
            do_reset_i = 1'b1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o == 1'b1, "R9", "frame continues after extra start", busy_o, 1);
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && cs_n_o == 1'b1, "R9", "no further frame", busy_o, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rises = 0; last_rise = -1; first_rise = -1; last_fall = 0;
        rst_fall = 0; rst_rise = 0; frames = 0; period_bad = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1 && sck_o == 0 && dev_rst_n_o == 1 && busy_o == 0 && mismatch_o == 0,
            "R1", "outputs during reset", {cs_n_o, sck_o, dev_rst_n_o, busy_o, mismatch_o}, 5'b10100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n_o == 1 && sck_o == 0 && dev_rst_n_o == 1 && busy_o == 0 && mismatch_o == 0,
            "R1", "outputs after reset", {cs_n_o, sck_o, dev_rst_n_o, busy_o, mismatch_o}, 5'b10100);
        mon_on = 1'b1;

        run_txn(6'h2A, 6'h15, 1'b0, 1'b1, 1'b0, 1'b0);  // R2 R3 R10 clean readback
        run_txn(6'h3F, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0);  // R7 reset first
        run_txn(6'h05, 6'h3A, 1'b0, 1'b1, 1'b1, 1'b0);  // R10 corrupted return
        run_txn(6'h0F, 6'h30, 1'b0, 1'b0, 1'b1, 1'b0);  // R10 compare disabled
        run_txn(6'h01, 6'h3E, 1'b0, 1'b0, 1'b0, 1'b1);  // R9 extra start ignored
        run_txn(6'h20, 6'h01, 1'b1, 1'b1, 1'b0, 1'b0);  // R3 boundary codes

        chk(idle_bad == 0, "R8", "bus quiet while idle", idle_bad, 0);
        chk(sdi_bad == 0, "R4", "data moves only on falling clock", sdi_bad, 0);
        chk(exp_q.size() == 0 && frames == 6, "R6", "one select rise per request", frames, 6);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule